// File: doc/BRIEF.md
# Bit-Serial Adder and Accumulator

This block adds two N-bit words one bit per clock through a single full adder. An accumulator register holds the augend and receives the sum bits at its top end as it shifts right. An operand register holds the addend and shifts right alongside it. A carry flip-flop links one bit position to the next. A pass takes N clocks. During a pass the operand register takes in a new word on its serial input while it hands its old bits to the adder. A later pass then adds that new word to the running sum, so a stream of words can be summed into the accumulator with no parallel bus for the operands.

A `go` pulse while idle arms a pass. A bit counter then keeps the shifter running for exactly N cycles and raises `fin` for one cycle. The carry flip-flop is cleared when a pass is armed. Its final value stays on `cy_out` until the next pass or a clear. Both registers can be preset in parallel while idle, and a synchronous clear empties both registers and the carry.

Top module: `serial_acc`

## Requirements
- R1: After reset, and one cycle after `clr` is sampled high, `acc_out` is 0, `cy_out` is 0, `busy` and `fin` are 0, and the operand register holds 0.
- R2: While idle with `clr` and `go` low, `ld_acc` loads `acc_in` into the accumulator and `ld_opd` loads `opd_in` into the operand register; `acc_out` shows the loaded value on the next cycle.
- R3: `go` sampled high while idle makes `busy` high for exactly N cycles, starting the next cycle. The cycle after the last of these has `busy` low and `fin` high for exactly one cycle.
- R4: At the end of a pass, `acc_out` equals (A + B) mod 2^N and `cy_out` equals the carry out of bit N-1, where A and B are the register contents when `go` was taken. The carry into bit 0 is 0 whatever `cy_out` held before.
- R5: The bit on `opd_ser` during the k-th busy cycle (k = 0 first) becomes bit k of the operand register, so the word enters least significant bit first.
- R6: Passes chain: each pass adds the operand that was shifted in during the previous pass to the running sum in the accumulator.
- R7: `cy_out` keeps its end-of-pass value through idle cycles, until the next accepted `go` clears it or `clr` is applied.
- R8: `go`, `ld_acc` and `ld_opd` have no effect while `busy` is high. While idle, `go` takes priority over both loads sampled in the same cycle, and those loads are dropped.
- R9: `clr` takes priority over `go`, loads and shifting. A pass cut short by `clr` ends the next cycle with `busy` low and no `fin` pulse.
- R10: While idle and with no load or clear, `acc_out` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| clr | input | 1 | Synchronous clear of both registers, the carry and the sequencer |
| go | input | 1 | Arms a pass of N shift cycles when idle |
| ld_acc | input | 1 | Parallel load of the accumulator when idle |
| acc_in | input | N | Parallel value for the accumulator |
| ld_opd | input | 1 | Parallel load of the operand register when idle |
| opd_in | input | N | Parallel value for the operand register |
| opd_ser | input | 1 | Serial input of the operand register, least significant bit first |
| acc_out | output | N | Accumulator contents |
| cy_out | output | 1 | Carry flip-flop |
| busy | output | 1 | High during the N shift cycles |
| fin | output | 1 | One-cycle pulse after the last shift |

## Verification
The bench builds the block with the default N = 4. At this width all 256 pairs of accumulator and operand values can each be run through a full pass, so every carry chain is exercised, including the full ripple from bit 0 to the carry out. The short pass also leaves room for cycles to chain passes, drop loads and `go` during a pass, cut a pass with `clr` at its last cycle, and hold the carry through long idle gaps.

// File: rtl/serial_acc_pkg.sv
package serial_acc_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sacc_shreg.sv
module sacc_shreg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         ser_in,
  output logic [W-1:0] q
);

  logic [W-1:0] shifted;
  logic [W-1:0] q_nx;
  logic         q_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign shifted[i] = ser_in;
    end else begin : g_mid
      assign shifted[i] = q[i+1];
    end
  end

  always_comb begin
    q_en = clr | shift | load;
    q_nx = q;
    if (clr) begin
      q_nx = '0;
    end else if (shift) begin
      q_nx = shifted;
    end else if (load) begin
      q_nx = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nx;
    end
  end

  // R5: the serial input lands in the top bit on each shift
  a_r5_ser_to_top: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (q[W-1] == $past(ser_in)));

  // R1: clear empties the register
  a_r1_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

endmodule

// File: rtl/sacc_carry.sv
module sacc_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic step,
  input  logic x,
  input  logic y,
  output logic sum,
  output logic q
);

  logic j_in;
  logic k_in;
  logic q_nx;
  logic q_en;

  always_comb begin
    sum  = x ^ y ^ q;
    j_in = x & y;
    k_in = ~(x | y);
    q_en = clr | arm | step;
    q_nx = q;
    if (clr || arm) begin
      q_nx = 1'b0;
    end else if (step) begin
      q_nx = (j_in & ~q) | (~k_in & q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (q_en) begin
      q <= q_nx;
    end
  end

  // R4: after a step the carry is the majority of the three adder inputs
  a_r4_carry_majority: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !arm) |=>
      (q == (($past(x) & $past(y)) | ($past(x) & $past(q)) | ($past(y) & $past(q)))));

  // R4: arming a pass starts from a zero carry
  a_r4_arm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !q);

  // R7: with no step, arm or clear, the carry is kept
  a_r7_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !arm && !clr) |=> $stable(q));

endmodule

// File: rtl/sacc_seq.sv
module sacc_seq
  import serial_acc_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic go,
  output logic busy,
  output logic fin,
  output logic arm
);

  localparam int unsigned CW = cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  seq_state_e    st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          fin_nx;
  logic          at_last;

  always_comb begin
    at_last = (cnt == LAST);
    arm     = (st == SEQ_IDLE) && go && !clr;
    st_nx   = st;
    cnt_nx  = cnt;
    fin_nx  = 1'b0;
    if (clr) begin
      st_nx  = SEQ_IDLE;
      cnt_nx = '0;
    end else if (st == SEQ_RUN) begin
      if (at_last) begin
        st_nx  = SEQ_IDLE;
        cnt_nx = '0;
        fin_nx = 1'b1;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end else if (go) begin
      st_nx  = SEQ_RUN;
      cnt_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SEQ_IDLE;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      fin <= fin_nx;
    end
  end

  assign busy = (st == SEQ_RUN);

  // R3: the pulse follows a busy cycle and never overlaps busy
  a_r3_fin_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!busy && $past(busy)));

  // R3: the counter stays inside the pass length
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) < int'(N)));

  // R3: a pass begins with the counter at zero
  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == '0));

  // R9: clear drops the pass with no pulse
  a_r9_clr_abort: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !fin));

endmodule

// File: rtl/serial_acc.sv
module serial_acc
  import serial_acc_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         go,
  input  logic         ld_acc,
  input  logic [N-1:0] acc_in,
  input  logic         ld_opd,
  input  logic [N-1:0] opd_in,
  input  logic         opd_ser,
  output logic [N-1:0] acc_out,
  output logic         cy_out,
  output logic         busy,
  output logic         fin
);

  logic         arm;
  logic         step;
  logic         idle_ld;
  logic         sum_bit;
  logic [N-1:0] acc_q;
  logic [N-1:0] opd_q;

  sacc_seq #(.N(N)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .go    (go),
    .busy  (busy),
    .fin   (fin),
    .arm   (arm)
  );

  always_comb begin
    step    = busy && !clr;
    idle_ld = !busy && !go && !clr;
  end

  sacc_carry u_carry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .arm   (arm),
    .step  (step),
    .x     (acc_q[0]),
    .y     (opd_q[0]),
    .sum   (sum_bit),
    .q     (cy_out)
  );

  sacc_shreg #(.W(N)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift    (step),
    .load     (idle_ld && ld_acc),
    .load_val (acc_in),
    .ser_in   (sum_bit),
    .q        (acc_q)
  );

  sacc_shreg #(.W(N)) u_opd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift    (step),
    .load     (idle_ld && ld_opd),
    .load_val (opd_in),
    .ser_in   (opd_ser),
    .q        (opd_q)
  );

  assign acc_out = acc_q;

  // R2: an idle load shows on the output next cycle
  a_r2_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld_acc && !go && !clr) |=> (acc_out == $past(acc_in)));

  // R10: idle with no load or clear keeps the accumulator
  a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_acc && !clr) |=> $stable(acc_out));

  // R8: arming a pass does not disturb the accumulator
  a_r8_go_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && !clr) |=> (busy && $stable(acc_out)));

  // R1: clear empties the carry and the accumulator
  a_r1_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((acc_out == '0) && !cy_out));

endmodule

// File: tb/tb_serial_acc.sv
module tb_serial_acc;

  localparam int N = 4;
  localparam int M = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         go = 1'b0;
  logic         ld_acc = 1'b0;
  logic [N-1:0] acc_in = '0;
  logic         ld_opd = 1'b0;
  logic [N-1:0] opd_in = '0;
  logic         opd_ser = 1'b0;
  logic [N-1:0] acc_out;
  logic         cy_out;
  logic         busy;
  logic         fin;

  serial_acc #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(go),
    .ld_acc(ld_acc), .acc_in(acc_in), .ld_opd(ld_opd), .opd_in(opd_in),
    .opd_ser(opd_ser), .acc_out(acc_out), .cy_out(cy_out),
    .busy(busy), .fin(fin)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Word-level reference: operands captured at arm, sum applied after N shifts
  int m_acc, m_opd, m_cy, m_cnt, m_opa, m_opb, m_new;
  bit m_busy, m_fin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_opd = 0; m_cy = 0; m_cnt = 0;
      m_busy = 0; m_fin = 0; m_opa = 0; m_opb = 0; m_new = 0;
    end else begin
      m_fin = 0;
      if (clr) begin
        m_acc = 0; m_opd = 0; m_cy = 0; m_busy = 0; m_cnt = 0;
      end else if (m_busy) begin
        m_new = m_new | (int'(opd_ser) << m_cnt);
        m_cnt++;
        if (m_cnt == N) begin
          m_acc  = (m_opa + m_opb) % M;
          m_cy   = ((m_opa + m_opb) >= M) ? 1 : 0;
          m_opd  = m_new;
          m_busy = 0;
          m_fin  = 1;
        end
      end else if (go) begin
        m_busy = 1; m_cnt = 0; m_opa = m_acc; m_opb = m_opd; m_new = 0; m_cy = 0;
      end else begin
        if (ld_acc) m_acc = int'(acc_in);
        if (ld_opd) m_opd = int'(opd_in);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " busy"}, int'(busy), int'(m_busy));
      chk({cur_req, " fin"}, int'(fin), int'(m_fin));
      if (!m_busy) begin
        chk({cur_req, " acc_out"}, int'(acc_out), m_acc);
        chk({cur_req, " cy_out"}, int'(cy_out), m_cy);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_both(input int a, input int b);
    ld_acc = 1'b1; acc_in = N'(a);
    ld_opd = 1'b1; opd_in = N'(b);
    @(negedge clk);
    ld_acc = 1'b0; ld_opd = 1'b0;
  endtask

  // Arms a pass and feeds ser_word LSB first; returns on the pulse cycle
  task automatic run_pass(input int ser_word);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int k = 0; k < N; k++) begin
      opd_ser = ser_word[k];
      @(negedge clk);
    end
    opd_ser = 1'b0;
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset acc", int'(acc_out), 0);
    chk("R1 reset flags", int'({cy_out, busy, fin}), 0);

    // R2: idle loads
    cur_req = "R2";
    load_both(9, 5);
    chk("R2 acc load", int'(acc_out), 9);
    idle(1);

    // R3 / R4: every operand pair through a pass
    cur_req = "R4";
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        load_both(a, b);
        run_pass((a * 3 + b) % M);
        chk("R3 fin pulse", int'({busy, fin}), 1);
        chk("R4 sum", int'(acc_out), (a + b) % M);
        chk("R4 carry", int'(cy_out), (a + b) >= M ? 1 : 0);
      end
    end
    @(negedge clk);
    chk("R3 fin one cycle", int'(fin), 0);

    // R4: prior carry of 1 does not leak into the next pass
    load_both(15, 1);
    run_pass(0);
    chk("R4 carry set", int'(cy_out), 1);
    load_both(0, 0);
    run_pass(0);
    chk("R4 no carry leak", int'(acc_out), 0);

    // R5 / R6: accumulate 3 + 6 + 2 starting from a cleared block
    cur_req = "R6";
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    run_pass(3);
    chk("R5 first pass sum", int'(acc_out), 0);
    run_pass(6);
    chk("R6 acc after 3", int'(acc_out), 3);
    run_pass(2);
    chk("R6 acc after 3+6", int'(acc_out), 9);
    run_pass(0);
    chk("R6 acc after 3+6+2", int'(acc_out), 11);

    // R7: carry held through idle, cleared by next go
    cur_req = "R7";
    load_both(12, 7);
    run_pass(0);
    idle(5);
    chk("R7 carry held", int'(cy_out), 1);
    go = 1'b1; @(negedge clk); go = 1'b0;
    chk("R7 carry cleared on go", int'(cy_out), 0);
    idle(N);

    // R8: go and loads ignored while busy; go beats loads when idle
    cur_req = "R8";
    load_both(4, 2);
    go = 1'b1; ld_acc = 1'b1; acc_in = N'(13);
    @(negedge clk);
    ld_acc = 1'b1; ld_opd = 1'b1; opd_in = N'(11); go = 1'b1;
    idle(N);
    go = 1'b0; ld_acc = 1'b0; ld_opd = 1'b0;
    chk("R8 busy inputs ignored", int'(acc_out), 6);
    idle(1);

    // R9: clear on the last shift cycle
    cur_req = "R9";
    load_both(5, 5);
    go = 1'b1; @(negedge clk); go = 1'b0;
    idle(N - 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 abort no fin", int'({busy, fin}), 0);
    chk("R9 abort acc", int'(acc_out), 0);
    run_pass(0);
    chk("R1 operand cleared", int'(acc_out), 0);

    // R10: idle hold with operand and serial input toggling
    cur_req = "R10";
    load_both(10, 3);
    opd_ser = 1'b1;
    idle(6);
    opd_ser = 1'b0;
    chk("R10 acc hold", int'(acc_out), 10);
    idle(2);

    finish_run();
  end

endmodule